// File: doc/BRIEF.md
# Serial Channel Data and Baud-Divider Register

This block is the combined data word and clock-rate setting for one serial channel. One 16-bit word holds two things. The upper seven bits hold a divider setting for the operating clock. The lower bits act as the channel's transmit/receive buffer: nine bits on a wide channel and eight on a narrow one, chosen by a parameter. On a narrow channel bit 8 always reads as zero.

Software reaches the word through a 16-bit bus port, and what it can reach depends on the channel state. While the channel is stopped, the whole word can be written and read back. While the channel runs, only the buffer bits take writes, and the divider field reads as zero. The receive shifter loads its parallel result into the buffer, and the transmit shifter reads the buffer continuously.

The block also makes the transmit clock enable. With the internal source selected, it divides the operating clock by the stored setting. With the external source selected, it synchronizes the serial clock pin and turns each rising edge into a one-cycle enable. When the channel starts with a divider value that the chosen protocol does not allow, a sticky error flag is raised.

Top module: `serChanBuf`

## Requirements
- R1: After reset the word reads 0000h, and both `txClkEn` and `cfgErr` are 0.
- R2: While `chanEn` is 0, a bus write stores all 16 bits, and `busRdata` returns the stored word in the same cycle.
- R3: While `chanEn` is 1, a bus write changes only the buffer bits. Bits 15..9 keep their earlier value, which is visible again once `chanEn` returns to 0.
- R4: While `chanEn` is 1, `busRdata[15:9]` reads as 0 and the buffer bits read normally.
- R5: When `rxLoad` is 1, the low buffer bits of `rxData` are stored at that clock edge. This wins over a bus write to the buffer bits in the same cycle. A divider write from the bus in that cycle still takes effect.
- R6: `txData` always equals the buffer bits, zero-extended to 9 bits.
- R7: With `clkSrcSel`=0 and `chanEn`=1, `txClkEn` pulses for one cycle every 2*(D+1) cycles, where D is bits 15..9. The counter restarts when `chanEn` rises, so the first pulse falls in the 2*(D+1)-th enabled cycle.
- R8: With `clkSrcSel`=1 and `chanEn`=1, each rising edge of `sclkIn` gives exactly one `txClkEn` pulse. It appears in the cycle after the second clock edge that samples the high level.
- R9: `cfgErr` is set one cycle after `chanEn` rises with an illegal setting. `protoMode` is encoded as 0 = clocked serial, 1 = UART and 2 = I2C. The illegal settings are: UART with D of 0 or 1, I2C with D of 0, and `clkSrcSel`=1 with D not 0. Once set, the flag holds until reset.
- R10: While `chanEn` is 0, `txClkEn` stays 0 whatever `sclkIn` or the divider does.
- R11: On a narrow instance (`WIDE_BUF`=0), bit 8 of `busRdata` and of `txData` is always 0, even after a write or receive load with that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Bus write strobe |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Bus read data, combinational |
| chanEn | input | 1 | Channel running |
| clkSrcSel | input | 1 | 0 = internal divider, 1 = external serial clock |
| protoMode | input | 2 | 0 clocked serial, 1 UART, 2 I2C |
| rxLoad | input | 1 | Receive shifter parallel load strobe |
| rxData | input | 9 | Receive shifter parallel word |
| txData | output | 9 | Buffer contents to the transmit shifter |
| sclkIn | input | 1 | External serial clock pin, asynchronous |
| txClkEn | output | 1 | One-cycle transmit clock enable |
| cfgErr | output | 1 | Sticky illegal-setting flag |

## Verification
The results fall due at different times, so each is sampled at its own point.

| Result | When it is due | How the bench samples it |
|---|---|---|
| Read data, `txData` | Same cycle as the stored state (combinational) | 1 ns after the negative edge that follows the write edge |
| Write and receive-load effects | One edge after the strobe | Same point, after that edge |
| `cfgErr` | One edge after `chanEn` is first sampled high | Checked as 0 before that edge and as 1 after it |
| Divider pulses | Cycle index 2*(D+1)-1, counting the cycle in which `chanEn` was driven high as index 0, then every 2*(D+1) cycles | Each negative edge is compared with that index |
| External-clock pulse | Two edges after `sclkIn` is driven high | Expected in exactly that one sample and in no neighbour |

// File: rtl/serChanPkg.sv
package serChanPkg;

  typedef enum logic [1:0] {
    MODE_CSI  = 2'd0,
    MODE_UART = 2'd1,
    MODE_I2C  = 2'd2,
    MODE_RSV  = 2'd3
  } chanMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrDiv;    // load divider field from bus
    logic wrBuf;    // load buffer bits from bus
    logic capRx;    // load buffer bits from receive shifter
    logic runDiv;   // run internal divider
    logic useExt;   // pass external clock edges
    logic hideDiv;  // divider field reads as zero
  } dpStrobe_t;

endpackage

// File: rtl/serChanCtrl.sv
module serChanCtrl
  import serChanPkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             rxLoad,
  input  logic             chanEn,
  input  logic             clkSrcSel,
  input  logic [1:0]       protoMode,
  input  logic [DIV_W-1:0] divVal,
  output dpStrobe_t        strobe,
  output logic             cfgErr
);

  chanMode_e modeSel;
  logic      enPrev;
  logic      illegal;
  logic      divZero;
  logic      divLeOne;

  assign modeSel  = chanMode_e'(protoMode);
  assign divZero  = (divVal == '0);
  assign divLeOne = (divVal <= DIV_W'(1));

  always_comb begin
    strobe.wrDiv   = busWr && !chanEn;
    strobe.wrBuf   = busWr && !rxLoad;
    strobe.capRx   = rxLoad;
    strobe.runDiv  = chanEn && !clkSrcSel;
    strobe.useExt  = chanEn && clkSrcSel;
    strobe.hideDiv = chanEn;
  end

  always_comb begin
    if (clkSrcSel) illegal = !divZero;
    else begin
      case (modeSel)
        MODE_UART: illegal = divLeOne;
        MODE_I2C:  illegal = divZero;
        default:   illegal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      enPrev <= chanEn;
      if (chanEn && !enPrev && illegal) cfgErr <= 1'b1;
    end
  end

  // R9: the flag never clears without reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

endmodule

// File: rtl/serChanDatapath.sv
module serChanDatapath
  import serChanPkg::*;
#(
  parameter int REG_W = 16,
  parameter int DIV_W = 7,
  parameter int BUF_W = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [REG_W-1:0]       busWdata,
  input  logic [REG_W-DIV_W-1:0] rxData,
  input  logic                   sclkIn,
  output logic [REG_W-1:0]       busRdata,
  output logic [REG_W-DIV_W-1:0] txData,
  output logic [DIV_W-1:0]       divVal,
  output logic                   tickOut
);

  localparam int LOW_W = REG_W - DIV_W;
  localparam int GAP_W = LOW_W - BUF_W;
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] divReg;
  logic [BUF_W-1:0] bufReg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntTerm;
  logic [DIV_W-1:0] hiField;
  logic             syncA, syncB, syncC;
  logic             divTick, extTick;

  // storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
      bufReg <= '0;
    end else begin
      if (strobe.wrDiv) divReg <= busWdata[REG_W-1 -: DIV_W];
      if (strobe.capRx)      bufReg <= rxData[BUF_W-1:0];
      else if (strobe.wrBuf) bufReg <= busWdata[BUF_W-1:0];
    end
  end

  // internal divider: period 2*(D+1), terminal count 2*D+1
  assign cntTerm = {divReg, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (!strobe.runDiv)  cnt <= '0;
    else if (cnt == cntTerm)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign divTick = strobe.runDiv && (cnt == cntTerm);

  // external clock: two-stage synchronizer plus edge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= sclkIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign extTick = strobe.useExt && syncB && !syncC;
  assign tickOut = divTick || extTick;

  // read and transmit views
  assign hiField = strobe.hideDiv ? '0 : divReg;
  assign divVal  = divReg;

  generate
    if (GAP_W > 0) begin : g_narrow
      assign busRdata = {hiField, {GAP_W{1'b0}}, bufReg};
      assign txData   = {{GAP_W{1'b0}}, bufReg};
      logic unusedHi;
      assign unusedHi = ^{busWdata[LOW_W-1 -: GAP_W], rxData[LOW_W-1 -: GAP_W]};
    end else begin : g_wide
      assign busRdata = {hiField, bufReg};
      assign txData   = bufReg;
    end
  endgenerate

  // R3: divider field frozen while running
  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hideDiv && $past(strobe.hideDiv)) |-> $stable(divReg));

  // R7: counter never passes its terminal value
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= cntTerm);

  // R8: an external edge gives a single-cycle pulse
  assert_ext_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    extTick |=> !extTick);

endmodule

// File: rtl/serChanBuf.sv
module serChanBuf
  import serChanPkg::*;
#(
  parameter int WIDE_BUF = 1,
  parameter int REG_W    = 16,
  parameter int DIV_W    = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [REG_W-1:0]       busWdata,
  output logic [REG_W-1:0]       busRdata,
  input  logic                   chanEn,
  input  logic                   clkSrcSel,
  input  logic [1:0]             protoMode,
  input  logic                   rxLoad,
  input  logic [REG_W-DIV_W-1:0] rxData,
  output logic [REG_W-DIV_W-1:0] txData,
  input  logic                   sclkIn,
  output logic                   txClkEn,
  output logic                   cfgErr
);

  localparam int LOW_W = REG_W - DIV_W;
  localparam int BUF_W = (WIDE_BUF != 0) ? LOW_W : LOW_W - 1;

  dpStrobe_t        strobe;
  logic [DIV_W-1:0] divVal;

  serChanCtrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .rxLoad(rxLoad),
    .chanEn(chanEn), .clkSrcSel(clkSrcSel), .protoMode(protoMode),
    .divVal(divVal), .strobe(strobe), .cfgErr(cfgErr)
  );

  serChanDatapath #(.REG_W(REG_W), .DIV_W(DIV_W), .BUF_W(BUF_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .rxData(rxData), .sclkIn(sclkIn), .busRdata(busRdata),
    .txData(txData), .divVal(divVal), .tickOut(txClkEn)
  );

  // R10: no enable while stopped (crosses control and datapath)
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> !txClkEn);

endmodule

// File: tb/test_serChanBuf.sv
module test_serChanBuf;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic        chanEn = 1'b0;
  logic        clkSrcSel = 1'b0;
  logic [1:0]  protoMode = 2'd0;
  logic        rxLoad = 1'b0;
  logic [8:0]  rxData = '0;
  logic        sclkIn = 1'b0;
  logic [15:0] rdW, rdN;
  logic [8:0]  txW, txN;
  logic        tickW, tickN, errW, errN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serChanBuf #(.WIDE_BUF(1)) i_serChanBuf (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata), .busRdata(rdW),
    .chanEn(chanEn), .clkSrcSel(clkSrcSel), .protoMode(protoMode),
    .rxLoad(rxLoad), .rxData(rxData), .txData(txW), .sclkIn(sclkIn),
    .txClkEn(tickW), .cfgErr(errW)
  );

  serChanBuf #(.WIDE_BUF(0)) i_narrow (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata), .busRdata(rdN),
    .chanEn(chanEn), .clkSrcSel(clkSrcSel), .protoMode(protoMode),
    .rxLoad(rxLoad), .rxData(rxData), .txData(txN), .sclkIn(sclkIn),
    .txClkEn(tickN), .cfgErr(errN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; chanEn = 1'b0; busWr = 1'b0; rxLoad = 1'b0; sclkIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // stopped write of a full word
  task automatic stoppedWrite(input logic [15:0] w);
    @(negedge clk);
    chanEn = 1'b0; busWr = 1'b1; busWdata = w;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic runDiv(input int d);
    int per;
    per = 2 * (d + 1);
    clkSrcSel = 1'b0; protoMode = 2'd0;
    stoppedWrite(16'(d << 9));
    chanEn = 1'b1;
    for (int k = 0; k < 4 * per; k++) begin
      #1 chk($sformatf("R7 div=%0d k=%0d", d, k), tickW, (k % per) == per - 1);
      @(negedge clk);
    end
    chanEn = 1'b0;
  endtask

  task automatic cfgCase(input string tag, input logic [6:0] d, input logic [1:0] m,
                         input logic src, input logic expErr);
    doReset();
    protoMode = m; clkSrcSel = src;
    stoppedWrite({d, 9'h000});
    chanEn = 1'b1;
    #1 chk({tag, " before edge"}, errW, 1'b0);
    @(negedge clk);
    #1 chk(tag, errW, expErr);
    chanEn = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk({tag, " sticky"}, errW, expErr);
  endtask

  // en, wr, wdata, expected read wide, expected read narrow
  localparam logic [49:0] VECS [0:5] = '{
    {1'b0, 1'b1, 16'hA5C3, 16'hA5C3, 16'hA4C3},
    {1'b1, 1'b1, 16'h0012, 16'h0012, 16'h0012},
    {1'b1, 1'b1, 16'hFFFF, 16'h01FF, 16'h00FF},
    {1'b0, 1'b0, 16'h0000, 16'hA5FF, 16'hA4FF},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 16'hFE01, 16'hFE01, 16'hFE01}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 read", rdW, 16'h0000);
    chk("R1 tick", tickW, 1'b0);
    chk("R1 err", errW, 1'b0);

    // table walk: R2 stopped writes, R3/R4 running writes and reads, R6, R11
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chanEn = VECS[i][49]; busWr = VECS[i][48]; busWdata = VECS[i][47:32];
      @(negedge clk);
      busWr = 1'b0;
      #1;
      chk($sformatf("R2/R3/R4 row%0d wide", i), rdW, VECS[i][31:16]);
      chk($sformatf("R11 row%0d narrow", i), rdN, VECS[i][15:0]);
      chk($sformatf("R6 row%0d tx", i), txW, VECS[i][24:16]);
      chk($sformatf("R11 row%0d tx narrow", i), txN, {1'b0, VECS[i][7:0]});
    end

    // R5: receive load wins over bus buffer write, divider write still lands
    @(negedge clk);
    chanEn = 1'b0; busWr = 1'b1; busWdata = 16'h7E55; rxLoad = 1'b1; rxData = 9'h1AB;
    @(negedge clk);
    busWr = 1'b0; rxLoad = 1'b0;
    #1;
    chk("R5 wide", rdW, 16'h7FAB);
    chk("R5 narrow R11", rdN, 16'h7EAB);
    chk("R5 tx R6", txW, 9'h1AB);

    // R7: internal divider periods
    runDiv(0);
    runDiv(2);

    // R10: stopped, pin toggling, divider value small
    stoppedWrite(16'h0000);
    for (int k = 0; k < 8; k++) begin
      sclkIn = ~sclkIn; clkSrcSel = k[1];
      @(negedge clk);
      #1 chk($sformatf("R10 k=%0d", k), tickW, 1'b0);
    end
    sclkIn = 1'b0;
    repeat (4) @(negedge clk);

    // R8: external clock edges
    clkSrcSel = 1'b1; protoMode = 2'd0;
    chanEn = 1'b1;
    repeat (4) @(negedge clk);
    for (int rep = 0; rep < 2; rep++) begin
      sclkIn = 1'b1;
      for (int k = 0; k < 6; k++) begin
        #1 chk($sformatf("R8 rep%0d k=%0d", rep, k), tickW, k == 2);
        @(negedge clk);
      end
      sclkIn = 1'b0;
      repeat (4) @(negedge clk);
    end
    #1 chk("R9 legal ext", errW, 1'b0);
    chanEn = 1'b0; clkSrcSel = 1'b0;

    // R9: setting checks
    cfgCase("R9 uart d1", 7'd1, 2'd1, 1'b0, 1'b1);
    cfgCase("R9 uart d0", 7'd0, 2'd1, 1'b0, 1'b1);
    cfgCase("R9 uart d2", 7'd2, 2'd1, 1'b0, 1'b0);
    cfgCase("R9 i2c d0", 7'd0, 2'd2, 1'b0, 1'b1);
    cfgCase("R9 i2c d1", 7'd1, 2'd2, 1'b0, 1'b0);
    cfgCase("R9 ext d3", 7'd3, 2'd0, 1'b1, 1'b1);
    cfgCase("R9 csi d0", 7'd0, 2'd0, 1'b0, 1'b0);
    doReset();
    #1 chk("R1 err cleared by reset", errW, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule